// File: doc/BRIEF.md
# Sleep and Interrupt Wake-Up Controller

This block sequences power-down and wake-up for a small 8-bit processor core. The core's decoder sends a one-clock strobe when it executes the sleep instruction, and another when it executes the watchdog-clear instruction. The block decides whether the sleep really takes effect. It then holds the core clock gate off while asleep and while the oscillator settles. On resume, it tells the fetch unit either to insert one dummy instruction cycle and then load the interrupt vector, or to carry on in-line with the next instruction.

Wake-up is driven by the per-source interrupt enable and flag vectors, or by a watchdog time-out. The global interrupt enable does not gate wake-up; it only selects between the vectored resume and the in-line resume. The block also keeps the two status bits software reads after a sleep: a time-out bit and a power-down bit. A sleep issued while a wake source is already pending leaves the power-down bit set, so software can tell that the sleep did nothing. A free-running two-bit phase counter marks the four oscillator clocks of each instruction cycle. Phase 0 is the first of the four.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After reset the time-out bit and the power-down bit are both 1, the core clock gate is enabled, the block is not asleep, and the phase counter is 0.
- R2: A wake source exists when at least one bit position has both its enable and its flag set. Flags whose enable is clear never wake the block. The global interrupt enable has no influence on whether the block wakes.
- R3: A sleep strobe seen while a wake source already exists acts as a no-op. The watchdog clear does not pulse, the time-out and power-down bits keep their values, and the core keeps running.
- R4: A sleep strobe seen while running with no wake source and no watchdog time-out enters sleep on the next clock. At that point the watchdog clear pulses for one clock, the time-out bit becomes 1, the power-down bit becomes 0, and the clock gate goes low.
- R5: A wake source that appears while asleep, including one that arrives on the clock right after the sleep strobe, leaves the sleep state on the next clock.
- R6: In the oscillator modes LP (0), XT (1) and HS (2), wake-up is followed by a start-up wait of 1024 clocks, during which the clock gate stays low.
- R7: In RC mode (3) the start-up wait is skipped.
- R8: The clock gate is re-enabled only on a clock whose phase counter reads 0.
- R9: If the global interrupt enable is 1 at resume, one dummy instruction cycle of 4 clocks follows, with the dummy indicator high. Then a one-clock vector load pulse presents address 0x004.
- R10: If the global interrupt enable is 0 at resume, a one-clock in-line resume pulse is given and no dummy cycle occurs.
- R11: A watchdog-clear strobe produces a watchdog clear pulse on the next clock.
- R12: A watchdog time-out while asleep wakes the block and clears the time-out bit.
- R13: A watchdog time-out while running clears the time-out bit and pulses the reset request on the next clock. Any sleep strobe in that same clock is ignored.
- R14: Sleep strobes are ignored whenever the block is not in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low power-on reset |
| sleep_req | input | 1 | Sleep instruction executed strobe |
| clrwdt_req | input | 1 | Watchdog-clear instruction strobe |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| irq_en | input | N_SRC | Per-source interrupt enables |
| irq_flag | input | N_SRC | Per-source interrupt flags |
| gie | input | 1 | Global interrupt enable |
| osc_mode | input | 2 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 RC |
| to_bit | output | 1 | Time-out status bit |
| pd_bit | output | 1 | Power-down status bit |
| wdt_clr | output | 1 | Clear pulse for the watchdog and its scalers |
| wdt_reset_req | output | 1 | Reset request after a running time-out |
| core_clk_en | output | 1 | Core clock gate enable |
| dummy_cycle | output | 1 | Fetch is in the dummy cycle |
| vector_load | output | 1 | Load the interrupt vector into the program counter |
| vec_addr | output | AW | Vector address, valid with vector_load |
| resume_inline | output | 1 | Resume with the instruction after sleep |
| asleep | output | 1 | Block is in the sleep state |
| q_phase | output | PW | Instruction-cycle phase, 0 marks the first |

## Verification
The critical overlap is between the sleep strobe and the rise of a wake source. The bench raises an enabled flag in the same clock as the strobe, and separately one clock later. The first case must leave the power-down bit at 1 with no watchdog clear. The second must complete the sleep, clearing power-down and pulsing the clear, and then wake at once. A second overlap is a watchdog time-out in the same clock as a sleep strobe: the bench expects a reset request with no sleep. The behavioural model predicts every output on every clock for these cases.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;

    typedef enum logic [1:0] {
        OSC_LP = 2'd0,
        OSC_XT = 2'd1,
        OSC_HS = 2'd2,
        OSC_RC = 2'd3
    } osc_mode_e;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_OST   = 3'd2,
        ST_ALIGN = 3'd3,
        ST_DUMMY = 3'd4
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e st;
        logic       to_b;
        logic       pd_b;
        logic       wdt_clr;
        logic       wdt_rst;
        logic       vec_ld;
        logic       resume;
    } ctl_s;

endpackage

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
    parameter int unsigned N_SRC = 8
) (
    input  logic [N_SRC-1:0] irq_en,
    input  logic [N_SRC-1:0] irq_flag,
    output logic             wake_any
);
    logic [N_SRC-1:0] armed;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign armed[i] = irq_en[i] & irq_flag[i];
    end

    assign wake_any = |armed;
endmodule

// File: rtl/slp_phase_gen.sv
module slp_phase_gen #(
    parameter int unsigned PHASES = 4,
    localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          last
);
    localparam logic [PW-1:0] PH_LAST = PW'(PHASES - 1);

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign phase = ph_q;
    assign last  = (ph_q == PH_LAST);
endmodule

// File: rtl/slp_ost_counter.sv
module slp_ost_counter #(
    parameter int unsigned OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic done
);
    localparam int unsigned CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(OST_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = count_en ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = count_en && (cnt_q == CNT_LAST);
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
    import slp_wake_pkg::*;
#(
    parameter int unsigned N_SRC      = 8,
    parameter int unsigned OST_CYCLES = 1024,
    parameter int unsigned PHASES     = 4,
    parameter int unsigned AW         = 13,
    parameter logic [AW-1:0] VEC_ADDR = 13'h0004,
    localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             clrwdt_req,
    input  logic             wdt_timeout,
    input  logic [N_SRC-1:0] irq_en,
    input  logic [N_SRC-1:0] irq_flag,
    input  logic             gie,
    input  logic [1:0]       osc_mode,
    output logic             to_bit,
    output logic             pd_bit,
    output logic             wdt_clr,
    output logic             wdt_reset_req,
    output logic             core_clk_en,
    output logic             dummy_cycle,
    output logic             vector_load,
    output logic [AW-1:0]    vec_addr,
    output logic             resume_inline,
    output logic             asleep,
    output logic [PW-1:0]    q_phase
);
    logic      wake_any;
    logic      ph_last;
    logic      ost_done;
    osc_mode_e osc;
    ctl_s      c_d, c_q;

    assign osc = osc_mode_e'(osc_mode);

    slp_wake_detect #(.N_SRC(N_SRC)) u_detect (
        .irq_en   (irq_en),
        .irq_flag (irq_flag),
        .wake_any (wake_any)
    );

    slp_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (q_phase),
        .last  (ph_last)
    );

    slp_ost_counter #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (c_q.st == ST_OST),
        .done     (ost_done)
    );

    always_comb begin
        c_d         = c_q;
        c_d.wdt_clr = clrwdt_req;
        c_d.wdt_rst = 1'b0;
        c_d.vec_ld  = 1'b0;
        c_d.resume  = 1'b0;
        if (wdt_timeout) c_d.to_b = 1'b0;

        unique case (c_q.st)
            ST_RUN: begin
                if (wdt_timeout) begin
                    c_d.wdt_rst = 1'b1;
                end else if (sleep_req && !wake_any) begin
                    c_d.st      = ST_SLEEP;
                    c_d.to_b    = 1'b1;
                    c_d.pd_b    = 1'b0;
                    c_d.wdt_clr = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (wake_any || wdt_timeout) begin
                    c_d.st = (osc == OSC_RC) ? ST_ALIGN : ST_OST;
                end
            end
            ST_OST: begin
                if (ost_done) c_d.st = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (ph_last) begin
                    c_d.st     = gie ? ST_DUMMY : ST_RUN;
                    c_d.resume = !gie;
                end
            end
            ST_DUMMY: begin
                if (ph_last) begin
                    c_d.st     = ST_RUN;
                    c_d.vec_ld = 1'b1;
                end
            end
            default: c_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_RUN, to_b: 1'b1, pd_b: 1'b1, wdt_clr: 1'b0,
                     wdt_rst: 1'b0, vec_ld: 1'b0, resume: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign to_bit        = c_q.to_b;
    assign pd_bit        = c_q.pd_b;
    assign wdt_clr       = c_q.wdt_clr;
    assign wdt_reset_req = c_q.wdt_rst;
    assign core_clk_en   = (c_q.st == ST_RUN) || (c_q.st == ST_DUMMY);
    assign dummy_cycle   = (c_q.st == ST_DUMMY);
    assign asleep        = (c_q.st == ST_SLEEP);
    assign vector_load   = c_q.vec_ld;
    assign vec_addr      = c_q.vec_ld ? VEC_ADDR : '0;
    assign resume_inline = c_q.resume;
endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk #(
    parameter int unsigned PW = 2,
    parameter int unsigned AW = 13,
    parameter logic [AW-1:0] VEC_ADDR = 13'h0004
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_req,
    input logic          clrwdt_req,
    input logic          wdt_timeout,
    input logic          wake_any,
    input logic          to_bit,
    input logic          pd_bit,
    input logic          wdt_clr,
    input logic          wdt_reset_req,
    input logic          core_clk_en,
    input logic          dummy_cycle,
    input logic          vector_load,
    input logic [AW-1:0] vec_addr,
    input logic          asleep,
    input logic [PW-1:0] q_phase
);
    logic running;
    assign running = core_clk_en && !dummy_cycle;

    // R11
    clr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clrwdt_req |=> wdt_clr);

    // R8
    q1_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (q_phase == '0));

    // R3
    nop_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && wake_any && running && !wdt_timeout) |=>
            (pd_bit == $past(pd_bit)) && (to_bit == $past(to_bit)) &&
            core_clk_en && (wdt_clr == $past(clrwdt_req)));

    // R4
    full_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !wake_any && running && !wdt_timeout) |=>
            asleep && !pd_bit && to_bit && wdt_clr);

    // R5
    wake_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && wake_any) |=> !asleep);

    // R9
    vec_after_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vector_load |-> ($past(dummy_cycle) && (vec_addr == VEC_ADDR)));

    // R13
    wdt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout && running) |=> (wdt_reset_req && !to_bit));
endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(
    .PW(PW), .AW(AW), .VEC_ADDR(VEC_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_req     (sleep_req),
    .clrwdt_req    (clrwdt_req),
    .wdt_timeout   (wdt_timeout),
    .wake_any      (wake_any),
    .to_bit        (to_bit),
    .pd_bit        (pd_bit),
    .wdt_clr       (wdt_clr),
    .wdt_reset_req (wdt_reset_req),
    .core_clk_en   (core_clk_en),
    .dummy_cycle   (dummy_cycle),
    .vector_load   (vector_load),
    .vec_addr      (vec_addr),
    .asleep        (asleep),
    .q_phase       (q_phase)
);

// File: tb/tb_slp_wake_ctrl.sv
`timescale 1ns/1ps
module tb_slp_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0, clrwdt_req = 1'b0, wdt_timeout = 1'b0;
    logic [7:0] irq_en = '0, irq_flag = '0;
    logic       gie = 1'b0;
    logic [1:0] osc_mode = 2'd1;
    logic       to_bit, pd_bit, wdt_clr, wdt_reset_req, core_clk_en;
    logic       dummy_cycle, vector_load, resume_inline, asleep;
    logic [12:0] vec_addr;
    logic [1:0] q_phase;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    slp_wake_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .clrwdt_req(clrwdt_req),
        .wdt_timeout(wdt_timeout), .irq_en(irq_en), .irq_flag(irq_flag), .gie(gie),
        .osc_mode(osc_mode), .to_bit(to_bit), .pd_bit(pd_bit), .wdt_clr(wdt_clr),
        .wdt_reset_req(wdt_reset_req), .core_clk_en(core_clk_en),
        .dummy_cycle(dummy_cycle), .vector_load(vector_load), .vec_addr(vec_addr),
        .resume_inline(resume_inline), .asleep(asleep), .q_phase(q_phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 run, 1 asleep, 2 start-up, 3 waiting for phase 0, 4 dummy
    int m_st, m_left, m_ph;
    int m_to, m_pd, m_clr, m_rst, m_vec, m_res;
    bit m_wk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_ph = 0;
            m_to = 1; m_pd = 1; m_clr = 0; m_rst = 0; m_vec = 0; m_res = 0;
        end else begin
            m_wk  = (irq_en & irq_flag) != 0;
            m_clr = clrwdt_req;
            m_rst = 0; m_vec = 0; m_res = 0;
            if (wdt_timeout) m_to = 0;
            case (m_st)
                0: if (wdt_timeout) m_rst = 1;
                   else if (sleep_req && !m_wk) begin
                       m_st = 1; m_to = 1; m_pd = 0; m_clr = 1;
                   end
                1: if (m_wk || wdt_timeout) begin
                       if (osc_mode == 2'd3) m_st = 3;
                       else begin m_st = 2; m_left = 1024; end
                   end
                2: begin m_left--; if (m_left == 0) m_st = 3; end
                3: if (m_ph == 3) begin
                       if (gie) m_st = 4;
                       else begin m_st = 0; m_res = 1; end
                   end
                default: if (m_ph == 3) begin m_st = 0; m_vec = 1; end
            endcase
            m_ph = (m_ph + 1) % 4;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 to_bit", to_bit, m_to);
            chk("R4 pd_bit", pd_bit, m_pd);
            chk("R11 wdt_clr", wdt_clr, m_clr);
            chk("R13 wdt_reset_req", wdt_reset_req, m_rst);
            chk("R6 core_clk_en", core_clk_en, (m_st == 0 || m_st == 4) ? 1 : 0);
            chk("R9 dummy_cycle", dummy_cycle, (m_st == 4) ? 1 : 0);
            chk("R9 vector_load", vector_load, m_vec);
            chk("R10 resume_inline", resume_inline, m_res);
            chk("R5 asleep", asleep, (m_st == 1) ? 1 : 0);
            chk("R8 q_phase", q_phase, m_ph);
            if (vector_load) chk("R9 vec_addr", vec_addr, 4);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic gap_len(output int g);
        g = 0;
        while (!core_clk_en && g < 5000) begin g++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int g;
        tick(3);
        // R1 reset state
        chk("R1 to", to_bit, 1); chk("R1 pd", pd_bit, 1);
        chk("R1 clk_en", core_clk_en, 1); chk("R1 asleep", asleep, 0);
        chk("R1 phase", q_phase, 0);
        rst_n = 1'b1;
        tick(3);

        // R11 watchdog clear strobe
        clrwdt_req = 1'b1; tick(1); clrwdt_req = 1'b0; tick(3);

        // R3 pending source turns sleep into a no-op
        irq_en = 8'h04; irq_flag = 8'h04;
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0; tick(3);
        chk("R3 pd stays set", pd_bit, 1);
        chk("R3 still running", core_clk_en, 1);
        irq_flag = '0; tick(2);

        // R6 R9 XT mode, vectored resume
        gie = 1'b1; osc_mode = 2'd1;
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0; tick(5);
        chk("R4 asleep", asleep, 1);
        irq_en = 8'h02; irq_flag = 8'h02;
        gap_len(g);
        chk("R6 start-up wait", (g >= 1024) ? 1 : 0, 1);
        tick(8);
        irq_flag = '0; tick(2);

        // R5 R7 R10 source rises one clock after the strobe, RC mode, in-line
        gie = 1'b0; osc_mode = 2'd3;
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0; irq_flag = 8'h02; tick(1);
        chk("R4 pd cleared", pd_bit, 0);
        gap_len(g);
        chk("R7 no start-up wait", (g < 8) ? 1 : 0, 1);
        tick(3);
        irq_flag = '0; tick(2);

        // R2 flags without enables do not wake; R14 sleep strobe during start-up
        irq_en = '0; irq_flag = 8'hFF; osc_mode = 2'd2; gie = 1'b1;
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0; tick(20);
        chk("R2 masked flags keep sleeping", asleep, 1);
        irq_en = 8'h80; tick(50);
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
        gap_len(g);
        tick(10);
        chk("R14 strobe ignored", asleep, 0);
        irq_en = '0; irq_flag = '0; tick(2);

        // R12 watchdog time-out while asleep, LP mode
        osc_mode = 2'd0;
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0; tick(4);
        wdt_timeout = 1'b1; tick(1); wdt_timeout = 1'b0;
        chk("R12 to cleared", to_bit, 0);
        gap_len(g);
        tick(8);

        // R13 time-out while running, together with a sleep strobe
        sleep_req = 1'b1; wdt_timeout = 1'b1; tick(1);
        sleep_req = 1'b0; wdt_timeout = 1'b0;
        chk("R13 reset request", wdt_reset_req, 1);
        chk("R13 no sleep", asleep, 0);
        tick(3);

        // R3 source rising in the same clock as the strobe
        irq_en = 8'h01; irq_flag = 8'h01; sleep_req = 1'b1; tick(1);
        sleep_req = 1'b0; tick(2);
        chk("R3 same-clock source", asleep, 0);
        tick(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule